// File: doc/BRIEF.md
# Transactional Conflict Resolution Arbiter

This block settles conflicts between hardware transactions that collide on a cache line. Each conflict report names a requesting transaction and the transaction that holds the line. It also carries their start timestamps, whether each side reads or writes, and whether the requester is committing. One cycle later the block returns a decision as three per-transaction masks: abort, stall and proceed. For every transaction it aborts, it also gives a back-off delay before that transaction may restart.

A two-bit configuration input picks the base policy. Under requester-wins the holder is aborted. Under requester-stalls the requester waits. Under committer-wins, conflicts between live transactions are let through and only a committing requester aborts the holder. Three extensions refine these policies. Age priority lets a requester win only when it started first. A starvation alarm lets a writer that has stalled too long abort the reader blocking it. A mutual-upgrade deadlock detector breaks a wait cycle between two transactions. Per-transaction back-off windows double on every abort, stop at a cap, and shrink back to the minimum on commit.

Top module: `tm_conflict_arbiter`

## Requirements
- R1: With `cfg_policy` = 0 (requester-wins) and age priority off, a conflict aborts the holder and lets the requester proceed.
- R2: With `cfg_policy` = 1 (requester-stalls, and also for value 3), a conflict stalls the requester and lets the holder proceed, unless R5 or R6 applies. A transaction is never marked with more than one of abort, stall and proceed.
- R3: With `cfg_policy` = 2 (committer-wins), a conflict whose `req_commit` is 1 aborts the holder and lets the requester proceed. A conflict with `req_commit` = 0 lets both sides proceed.
- R4: With `cfg_age_prio` = 1 under requester-wins, the requester wins only if it is older. Otherwise it stalls and the holder proceeds. Older means the 8-bit wrapped difference requester-minus-holder is negative. Equal timestamps go to the lower transaction ID.
- R5: Under requester-stalls with `cfg_starve_en` = 1, a write request from a transaction that has been stalled for more than `cfg_starve_limit` cycles aborts a holder that only reads, and the requester proceeds. A holder that writes still stalls the requester. The stall count starts at 0 on the edge that first stalls the transaction and rises by one on every later edge until that transaction proceeds as requester, aborts or commits.
- R6: Under requester-stalls, if the holder is itself stalled waiting on the requester, the requester is aborted and the holder proceeds.
- R7: Each back-off report carries shift = MIN_SHIFT + k. Here k is the number of earlier aborts of that transaction since its last commit, capped at MAX_DOUBLINGS. A commit on `commit_valid`/`commit_id` sets k back to 0.
- R8: The reported back-off delay is a pseudo-random value strictly below 2^shift.
- R9: After reset and on every cycle without a conflict on the previous edge, `dec_valid` and all masks are 0. A conflict presented at one edge yields its decision right after that edge.
- R10: Every decision aborts at most one transaction. `bo_valid` is 1 exactly when the abort mask is non-zero, and `bo_id` names the aborted transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_policy | input | 2 | 0 requester-wins, 1 requester-stalls, 2 committer-wins |
| cfg_age_prio | input | 1 | Enable age priority in requester-wins |
| cfg_starve_en | input | 1 | Enable writer starvation override |
| cfg_starve_limit | input | 8 | Stall cycles a writer may exceed before the override applies |
| conflict_valid | input | 1 | A conflict report is present |
| req_id | input | 2 | Requesting transaction |
| hold_id | input | 2 | Holding transaction |
| req_ts | input | 8 | Requester start timestamp |
| hold_ts | input | 8 | Holder start timestamp |
| req_write | input | 1 | Requester wants write access |
| hold_write | input | 1 | Holder has written the line |
| req_commit | input | 1 | Requester is committing |
| commit_valid | input | 1 | A transaction committed |
| commit_id | input | 2 | Committed transaction |
| dec_valid | output | 1 | Decision present |
| abort_mask | output | 4 | Transactions to abort |
| stall_mask | output | 4 | Transactions to stall |
| proceed_mask | output | 4 | Transactions that proceed |
| bo_valid | output | 1 | Back-off report present |
| bo_id | output | 2 | Transaction that must back off |
| bo_shift | output | 3 | Log2 of the back-off window |
| bo_delay | output | 6 | Back-off delay in cycles |

## Verification
The hardest situations to reach are the starvation override and the mutual-upgrade deadlock. Both depend on state left behind by an earlier stall rather than on the current report. For the override, the bench stalls a writer and then waits an exact number of idle cycles, sweeping that gap across the limit. It then presents the same write again and checks the decision against that gap. For the deadlock, the bench first stalls one reader's upgrade and then issues the reverse upgrade from the other reader. Between tests, commits clear the stall and back-off history so that each case starts from a known state.

// File: rtl/tm_arb_pkg.sv
// Shared definitions for the transactional conflict arbiter.
package tm_arb_pkg;
    // Base resolution policy encodings (value 3 behaves as requester-stalls).
    typedef enum logic [1:0] {
        POL_REQ_WINS    = 2'd0,
        POL_REQ_STALLS  = 2'd1,
        POL_COMMIT_WINS = 2'd2,
        POL_SPARE       = 2'd3
    } pol_e;
endpackage

// File: rtl/tm_age_cmp.sv
// Wraparound-safe age comparison of two transactions.
// Assumes live timestamps are within half the counter range of each other.
// a_wins is 1 when transaction a started first, or on equal stamps when
// a carries the lower ID.
module tm_age_cmp #(
    parameter int TS_W = 8,
    parameter int IDW  = 2
) (
    input  logic [TS_W-1:0] a_ts,
    input  logic [TS_W-1:0] b_ts,
    input  logic [IDW-1:0]  a_id,
    input  logic [IDW-1:0]  b_id,
    output logic            a_wins
);
    logic [TS_W-1:0] diff;

    // Signed wrapped difference decides age; ties fall to the lower ID.
    always_comb begin
        diff = a_ts - b_ts;
        if (diff == '0) a_wins = (a_id < b_id);
        else            a_wins = diff[TS_W-1];
    end
endmodule

// File: rtl/tm_stall_track.sv
// Per-transaction stall bookkeeping: whether the transaction is waiting,
// on whom it waits, and how many cycles it has waited (saturating).
// Assumes clear and set are not given to the same transaction together;
// clear takes priority if they are.
module tm_stall_track #(
    parameter int NTX   = 4,
    parameter int IDW   = 2,
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NTX-1:0]       set_mask,
    input  logic [IDW-1:0]       set_tgt,
    input  logic [NTX-1:0]       clr_mask,
    output logic [NTX-1:0]       waiting,
    output logic [NTX*IDW-1:0]   tgt_flat,
    output logic [NTX*CNT_W-1:0] cnt_flat
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar i = 0; i < NTX; i++) begin : g_tx
        logic [IDW-1:0]   tgt_q;
        logic [CNT_W-1:0] cnt_q;
        logic             wait_q;

        // Track wait state, target and elapsed wait cycles of one transaction.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wait_q <= 1'b0;
                tgt_q  <= '0;
                cnt_q  <= '0;
            end else if (clr_mask[i]) begin
                wait_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                if (set_mask[i]) begin
                    wait_q <= 1'b1;
                    tgt_q  <= set_tgt;
                end
                if (!wait_q)                   cnt_q <= '0;
                else if (cnt_q != CNT_MAX)     cnt_q <= cnt_q + 1'b1;
            end
        end

        assign waiting[i]                   = wait_q;
        assign tgt_flat[i*IDW +: IDW]       = tgt_q;
        assign cnt_flat[i*CNT_W +: CNT_W]   = cnt_q;
    end
endmodule

// File: rtl/tm_backoff.sv
// Per-transaction exponential back-off generator.
// Each abort reports a window of 2^(MIN_SH + k), where k counts earlier aborts
// since the last commit (capped), plus a pseudo-random delay inside it.
// Assumes at most one abort per cycle; a commit outranks an abort of the
// same transaction in the same cycle.
module tm_backoff #(
    parameter int NTX     = 4,
    parameter int IDW     = 2,
    parameter int MIN_SH  = 2,
    parameter int MAX_CNT = 4,
    parameter int SHW     = 3,
    parameter int DLY_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ab_valid,
    input  logic [IDW-1:0]   ab_id,
    input  logic             cm_valid,
    input  logic [IDW-1:0]   cm_id,
    output logic             bo_valid,
    output logic [IDW-1:0]   bo_id,
    output logic [SHW-1:0]   bo_shift,
    output logic [DLY_W-1:0] bo_delay
);
    localparam int CW = $clog2(MAX_CNT + 1);

    logic [CW-1:0]    cnt [NTX];
    logic [15:0]      lfsr;
    logic [SHW-1:0]   shift_n;
    logic [DLY_W-1:0] mask_n;

    for (genvar i = 0; i < NTX; i++) begin : g_cnt
        // Grow the doubling count on abort, clear it on commit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt[i] <= '0;
            else if (cm_valid && cm_id == IDW'(i))
                cnt[i] <= '0;
            else if (ab_valid && ab_id == IDW'(i) && cnt[i] != CW'(MAX_CNT))
                cnt[i] <= cnt[i] + 1'b1;
        end
    end

    // Free-running Galois LFSR as the pseudo-random source.
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr <= 16'hACE1;
        else        lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
    end

    // Window exponent and mask for the transaction being aborted now.
    always_comb begin
        shift_n = SHW'(MIN_SH) + SHW'(cnt[ab_id]);
        mask_n  = (DLY_W'(1) << shift_n) - DLY_W'(1);
    end

    // Register the back-off report alongside the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bo_valid <= 1'b0;
            bo_id    <= '0;
            bo_shift <= '0;
            bo_delay <= '0;
        end else begin
            bo_valid <= ab_valid;
            bo_id    <= ab_valid ? ab_id : '0;
            bo_shift <= ab_valid ? shift_n : '0;
            bo_delay <= ab_valid ? (lfsr[DLY_W-1:0] & mask_n) : '0;
        end
    end
endmodule

// File: rtl/tm_conflict_arbiter.sv
// Conflict resolution arbiter for hardware transactions.
// Takes one requester/holder conflict report per cycle and registers
// abort/stall/proceed masks plus a back-off report one cycle later.
// Assumes req_id differs from hold_id on a valid report.
module tm_conflict_arbiter
    import tm_arb_pkg::*;
#(
    parameter int NTX     = 4,
    parameter int TS_W    = 8,
    parameter int LIM_W   = 8,
    parameter int MIN_SH  = 2,
    parameter int MAX_CNT = 4,
    localparam int IDW    = $clog2(NTX),
    localparam int DLY_W  = MIN_SH + MAX_CNT,
    localparam int SHW    = $clog2(DLY_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_policy,
    input  logic             cfg_age_prio,
    input  logic             cfg_starve_en,
    input  logic [LIM_W-1:0] cfg_starve_limit,
    input  logic             conflict_valid,
    input  logic [IDW-1:0]   req_id,
    input  logic [IDW-1:0]   hold_id,
    input  logic [TS_W-1:0]  req_ts,
    input  logic [TS_W-1:0]  hold_ts,
    input  logic             req_write,
    input  logic             hold_write,
    input  logic             req_commit,
    input  logic             commit_valid,
    input  logic [IDW-1:0]   commit_id,
    output logic             dec_valid,
    output logic [NTX-1:0]   abort_mask,
    output logic [NTX-1:0]   stall_mask,
    output logic [NTX-1:0]   proceed_mask,
    output logic             bo_valid,
    output logic [IDW-1:0]   bo_id,
    output logic [SHW-1:0]   bo_shift,
    output logic [DLY_W-1:0] bo_delay
);
    pol_e                 pol;
    logic                 req_older;
    logic [NTX-1:0]       req_oh, hold_oh, cm_oh;
    logic [NTX-1:0]       abort_n, stall_n, proceed_n, clr_n;
    logic                 req_go;
    logic [NTX-1:0]       waiting;
    logic [NTX*IDW-1:0]   tgt_flat;
    logic [NTX*LIM_W-1:0] cnt_flat;
    logic                 deadlock, starved;
    logic [IDW-1:0]       ab_id_n;

    assign pol     = pol_e'(cfg_policy);
    assign req_oh  = NTX'(1) << req_id;
    assign hold_oh = NTX'(1) << hold_id;
    assign cm_oh   = commit_valid ? (NTX'(1) << commit_id) : '0;

    tm_age_cmp #(.TS_W(TS_W), .IDW(IDW)) u_age (
        .a_ts(req_ts), .b_ts(hold_ts), .a_id(req_id), .b_id(hold_id),
        .a_wins(req_older)
    );

    // Detect a wait cycle and a starving writer from the stall history.
    always_comb begin
        deadlock = waiting[hold_id] && (tgt_flat[hold_id*IDW +: IDW] == req_id);
        starved  = cfg_starve_en && req_write && !hold_write && waiting[req_id]
                   && (cnt_flat[req_id*LIM_W +: LIM_W] > cfg_starve_limit);
    end

    // Resolve the current conflict under the selected policy.
    always_comb begin
        abort_n   = '0;
        stall_n   = '0;
        proceed_n = '0;
        req_go    = 1'b0;
        ab_id_n   = hold_id;
        if (conflict_valid) begin
            case (pol)
                POL_REQ_WINS: begin
                    if (cfg_age_prio && !req_older) begin
                        stall_n   = req_oh;
                        proceed_n = hold_oh;
                    end else begin
                        abort_n   = hold_oh;
                        proceed_n = req_oh;
                        req_go    = 1'b1;
                    end
                end
                POL_COMMIT_WINS: begin
                    req_go = 1'b1;
                    if (req_commit) begin
                        abort_n   = hold_oh;
                        proceed_n = req_oh;
                    end else begin
                        proceed_n = req_oh | hold_oh;
                    end
                end
                default: begin
                    if (deadlock) begin
                        abort_n   = req_oh;
                        proceed_n = hold_oh;
                        ab_id_n   = req_id;
                    end else if (starved) begin
                        abort_n   = hold_oh;
                        proceed_n = req_oh;
                        req_go    = 1'b1;
                    end else begin
                        stall_n   = req_oh;
                        proceed_n = hold_oh;
                    end
                end
            endcase
        end
        clr_n = abort_n | (req_go ? req_oh : '0) | cm_oh;
    end

    tm_stall_track #(.NTX(NTX), .IDW(IDW), .CNT_W(LIM_W)) u_stall (
        .clk(clk), .rst_n(rst_n),
        .set_mask(stall_n), .set_tgt(hold_id), .clr_mask(clr_n),
        .waiting(waiting), .tgt_flat(tgt_flat), .cnt_flat(cnt_flat)
    );

    tm_backoff #(.NTX(NTX), .IDW(IDW), .MIN_SH(MIN_SH), .MAX_CNT(MAX_CNT),
                 .SHW(SHW), .DLY_W(DLY_W)) u_bo (
        .clk(clk), .rst_n(rst_n),
        .ab_valid(abort_n != '0), .ab_id(ab_id_n),
        .cm_valid(commit_valid), .cm_id(commit_id),
        .bo_valid(bo_valid), .bo_id(bo_id), .bo_shift(bo_shift), .bo_delay(bo_delay)
    );

    // Register the decision masks one cycle after the report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid    <= 1'b0;
            abort_mask   <= '0;
            stall_mask   <= '0;
            proceed_mask <= '0;
        end else begin
            dec_valid    <= conflict_valid;
            abort_mask   <= abort_n;
            stall_mask   <= stall_n;
            proceed_mask <= proceed_n;
        end
    end
endmodule

// File: rtl/tm_conflict_arbiter_sva.sv
// Property checker for the conflict arbiter, bound to every instance.
module tm_conflict_arbiter_sva #(
    parameter int NTX    = 4,
    parameter int IDW    = 2,
    parameter int MIN_SH = 2,
    parameter int MAX_CNT= 4,
    parameter int SHW    = 3,
    parameter int DLY_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conflict_valid,
    input logic             dec_valid,
    input logic [NTX-1:0]   abort_mask,
    input logic [NTX-1:0]   stall_mask,
    input logic [NTX-1:0]   proceed_mask,
    input logic             bo_valid,
    input logic [IDW-1:0]   bo_id,
    input logic [SHW-1:0]   bo_shift,
    input logic [DLY_W-1:0] bo_delay
);
    a_r9_decision_follows_report: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && $past(conflict_valid)) |-> dec_valid);
    a_r9_no_spurious_decision: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && !$past(conflict_valid)) |-> !dec_valid);
    a_r9_quiet_masks: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> ((abort_mask | stall_mask | proceed_mask) == '0));
    a_r2_disjoint_marks: assert property (@(posedge clk) disable iff (!rst_n)
        ((abort_mask & stall_mask) == '0) && ((abort_mask & proceed_mask) == '0)
        && ((stall_mask & proceed_mask) == '0));
    a_r10_single_abort: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(abort_mask));
    a_r10_backoff_pairs_abort: assert property (@(posedge clk) disable iff (!rst_n)
        bo_valid == (abort_mask != '0));
    a_r10_backoff_names_victim: assert property (@(posedge clk) disable iff (!rst_n)
        bo_valid |-> abort_mask[bo_id]);
    a_r7_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
        bo_valid |-> (int'(bo_shift) >= MIN_SH && int'(bo_shift) <= MIN_SH + MAX_CNT));
    a_r8_delay_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        bo_valid |-> ((DLY_W+1)'(bo_delay) < ((DLY_W+1)'(1) << bo_shift)));
endmodule

bind tm_conflict_arbiter tm_conflict_arbiter_sva #(
    .NTX(NTX), .IDW(IDW), .MIN_SH(MIN_SH), .MAX_CNT(MAX_CNT), .SHW(SHW), .DLY_W(DLY_W)
) u_sva (
    .clk(clk), .rst_n(rst_n), .conflict_valid(conflict_valid), .dec_valid(dec_valid),
    .abort_mask(abort_mask), .stall_mask(stall_mask), .proceed_mask(proceed_mask),
    .bo_valid(bo_valid), .bo_id(bo_id), .bo_shift(bo_shift), .bo_delay(bo_delay)
);

// File: tb/tm_conflict_arbiter_tb.sv
`timescale 1ns/100ps
// Sweep-based self-checking bench for the conflict arbiter (4 transactions).
module tm_conflict_arbiter_tb;
    localparam int NTX = 4, MIN_SH = 2, MAX_CNT = 4;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [1:0] cfg_policy = 2'd0;
    logic       cfg_age_prio = 1'b0, cfg_starve_en = 1'b0;
    logic [7:0] cfg_starve_limit = 8'd3;
    logic       conflict_valid = 1'b0;
    logic [1:0] req_id = '0, hold_id = '0;
    logic [7:0] req_ts = '0, hold_ts = '0;
    logic       req_write = 1'b0, hold_write = 1'b0, req_commit = 1'b0;
    logic       commit_valid = 1'b0;
    logic [1:0] commit_id = '0;
    logic       dec_valid, bo_valid;
    logic [3:0] abort_mask, stall_mask, proceed_mask;
    logic [1:0] bo_id;
    logic [2:0] bo_shift;
    logic [5:0] bo_delay;

    int checks = 0, fails = 0;
    int bcnt [NTX];
    logic done = 1'b0;

    tm_conflict_arbiter u_dut (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Present one conflict at the next edge and check the decision after it.
    task automatic fire(input string tag, input logic [1:0] pol, input int r, input int h,
                        input logic [7:0] rts, input logic [7:0] hts,
                        input logic rw, input logic hw, input logic rc,
                        input int ex_ab, input int ex_st, input int ex_pr);
        cfg_policy = pol; req_id = 2'(r); hold_id = 2'(h);
        req_ts = rts; hold_ts = hts; req_write = rw; hold_write = hw; req_commit = rc;
        conflict_valid = 1'b1;
        @(negedge clk);
        conflict_valid = 1'b0;
        chk({tag, " dec_valid (R9)"}, int'(dec_valid), 1);
        chk({tag, " abort"}, int'(abort_mask), ex_ab);
        chk({tag, " stall"}, int'(stall_mask), ex_st);
        chk({tag, " proceed"}, int'(proceed_mask), ex_pr);
        if (ex_ab != 0) begin
            int v = (ex_ab == 1) ? 0 : (ex_ab == 2) ? 1 : (ex_ab == 4) ? 2 : 3;
            int s = MIN_SH + ((bcnt[v] < MAX_CNT) ? bcnt[v] : MAX_CNT);
            chk({tag, " bo_valid (R10)"}, int'(bo_valid), 1);
            chk({tag, " bo_id (R10)"}, int'(bo_id), v);
            chk({tag, " bo_shift (R7)"}, int'(bo_shift), s);
            chk({tag, " delay below window (R8)"}, int'(int'(bo_delay) < (1 << s)), 1);
            bcnt[v]++;
        end else begin
            chk({tag, " no back-off (R10)"}, int'(bo_valid), 0);
        end
    endtask

    task automatic commit(input int t);
        commit_valid = 1'b1; commit_id = 2'(t);
        @(negedge clk);
        commit_valid = 1'b0;
        bcnt[t] = 0;
    endtask

    task automatic commit_all();
        for (int t = 0; t < NTX; t++) commit(t);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic bit older(input logic [7:0] a, input logic [7:0] b,
                                 input int ai, input int bi);
        logic signed [7:0] d = $signed(a - b);
        return (d < 0) || (d == 0 && ai < bi);
    endfunction

    initial begin
        logic [7:0] tsv [6] = '{8'd0, 8'd1, 8'd127, 8'd128, 8'd200, 8'd255};
        for (int t = 0; t < NTX; t++) bcnt[t] = 0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("reset dec_valid R9", int'(dec_valid), 0);
        chk("reset masks R9", int'(abort_mask | stall_mask | proceed_mask), 0);
        chk("reset bo_valid R9", int'(bo_valid), 0);

        // R1 and R7: requester-wins over every pair; windows grow per holder
        for (int r = 0; r < NTX; r++)
            for (int h = 0; h < NTX; h++)
                if (r != h) fire("R1 req-wins", 2'd0, r, h, 8'd5, 8'd9, 1, 0, 0,
                                 1 << h, 0, 1 << r);
        // R9: idle cycle after a decision is quiet
        idle(1);
        chk("idle quiet R9", int'(dec_valid | (|abort_mask) | bo_valid), 0);
        // R7: saturate tx1 window, then a commit shrinks it
        for (int k = 0; k < 4; k++) fire("R7 saturate", 2'd0, 0, 1, 8'd0, 8'd0, 0, 0, 0, 2, 0, 1);
        chk("R7 window capped", int'(bo_shift), MIN_SH + MAX_CNT);
        commit(1);
        fire("R7 after commit", 2'd0, 2, 1, 8'd0, 8'd0, 0, 0, 0, 2, 0, 4);
        chk("R7 window reset", int'(bo_shift), MIN_SH);
        commit_all();

        // R2: requester-stalls over every pair, both policy codes 1 and 3
        for (int p = 1; p <= 3; p += 2)
            for (int r = 0; r < NTX; r++)
                for (int h = 0; h < NTX; h++)
                    if (r != h) begin
                        fire("R2 req-stalls", 2'(p), r, h, 8'd1, 8'd2, 1, 0, 0, 0, 1 << r, 1 << h);
                        commit(r);
                    end

        // R3: committer-wins with and without commit
        for (int r = 0; r < NTX; r++)
            for (int h = 0; h < NTX; h++)
                if (r != h) begin
                    fire("R3 live", 2'd2, r, h, 8'd3, 8'd4, 1, 1, 0, 0, 0, (1 << r) | (1 << h));
                    fire("R3 commit", 2'd2, r, h, 8'd3, 8'd4, 1, 1, 1, 1 << h, 0, 1 << r);
                end
        commit_all();

        // R4: age priority with wrapped timestamps and ID tie-break
        cfg_age_prio = 1'b1;
        for (int r = 0; r < NTX; r++)
            for (int h = 0; h < NTX; h++)
                if (r != h)
                    for (int i = 0; i < 6; i++)
                        for (int j = 0; j < 6; j++) begin
                            if (older(tsv[i], tsv[j], r, h))
                                fire("R4 older wins", 2'd0, r, h, tsv[i], tsv[j], 0, 0, 0,
                                     1 << h, 0, 1 << r);
                            else
                                fire("R4 younger stalls", 2'd0, r, h, tsv[i], tsv[j], 0, 0, 0,
                                     0, 1 << r, 1 << h);
                        end
        cfg_age_prio = 1'b0;
        commit_all();

        // R5: starvation override swept across the limit
        cfg_starve_en = 1'b1;
        for (int w = 0; w <= 6; w++) begin
            fire("R5 first stall", 2'd1, 2, 3, 8'd0, 8'd0, 1, 0, 0, 0, 4, 8);
            idle(w);
            if (w > int'(cfg_starve_limit))
                fire("R5 override", 2'd1, 2, 3, 8'd0, 8'd0, 1, 0, 0, 8, 0, 4);
            else
                fire("R5 within limit", 2'd1, 2, 3, 8'd0, 8'd0, 1, 0, 0, 0, 4, 8);
            commit(2);
        end
        fire("R5 writer holder", 2'd1, 2, 3, 8'd0, 8'd0, 1, 1, 0, 0, 4, 8);
        idle(6);
        fire("R5 writer holder kept", 2'd1, 2, 3, 8'd0, 8'd0, 1, 1, 0, 0, 4, 8);
        fire("R5 read req no override", 2'd1, 2, 3, 8'd0, 8'd0, 0, 0, 0, 0, 4, 8);
        cfg_starve_en = 1'b0;
        commit_all();

        // R6: mutual upgrade deadlock, both directions
        fire("R6 first upgrade", 2'd1, 0, 1, 8'd0, 8'd1, 1, 0, 0, 0, 1, 2);
        fire("R6 reverse upgrade", 2'd1, 1, 0, 8'd1, 8'd0, 1, 0, 0, 2, 0, 1);
        commit_all();
        fire("R6 first upgrade b", 2'd1, 3, 2, 8'd0, 8'd1, 1, 0, 0, 0, 8, 4);
        idle(2);
        fire("R6 reverse upgrade b", 2'd1, 2, 3, 8'd1, 8'd0, 1, 0, 0, 4, 0, 8);
        fire("R6 unrelated stays stall", 2'd1, 1, 0, 8'd1, 8'd0, 1, 0, 0, 0, 2, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule